// File: doc/BRIEF.md
# Shared Output-Enable / Refresh Pin Decoder

This block is the device-side control logic of a pseudo-static RAM whose output-enable pin doubles as a refresh command pin. A sampling clock samples the active-low chip-select and the shared pin. With chip-select asserted (low), the shared pin is simply the read output enable. With chip-select released (high), a low pulse on the shared pin is a refresh command. The block times how long the pulse stays low and picks the refresh mode from that length. A short pulse requests exactly one row refresh. A pulse that stays low past a long threshold puts the part into self-refresh, and rows are then refreshed on an internal timer until the pin returns high.

Every refresh, whichever mode issued it, takes its row from an internal row counter that steps by one each time and wraps. The block also reports timing abuse of the pins: refresh pulses that are too short, gaps between pulses that are too short, chip-select returning too soon after a refresh, and pin activity during the power-up settling interval. All timing limits are parameters counted in sampling-clock cycles. The defaults assume a 200 MHz sampling clock. The inputs are taken to be synchronous to that clock. The memory array is outside this block.

Top module: `psr_rfsh_decoder`

## Requirements
- R1: `out_en` is high exactly when `init_busy` is low, `ce_n` is low, `rfsh_oe_n` is low and no refresh pulse or self-refresh is in progress; while `ce_n` is high, `out_en` is low.
- R2: A low pulse on `rfsh_oe_n` that starts while `ce_n` is high and lasts W sampled cycles, with W below SELF_CYC, is an auto-refresh. In the cycle after the first cycle that sees the pin high (or `ce_n` low), `auto_stb` and `refresh_stb` are each high for one cycle. No refresh strobe occurs while the pulse is low.
- R3: Once the pin has been sampled low for SELF_CYC consecutive cycles with `ce_n` high, the block enters self-refresh. In the cycle after the SELF_CYC-th low cycle, `self_active` goes high and one `refresh_stb` is issued, with `auto_stb` low.
- R4: While in self-refresh, a further `refresh_stb` is issued every SELF_ROW_CYC cycles. Self-refresh ends when the first cycle sees the pin high or `ce_n` low, and `self_active` is low from the following cycle. A self-refresh that stays low for L cycles gives 1 + floor((L - SELF_CYC) / SELF_ROW_CYC) strobes.
- R5: `refresh_row` is valid with `refresh_stb` and carries the row counter value. The counter is 0 after reset, steps by one per strobe, and wraps modulo 2^ROW_W (256 by default).
- R6: `viol_short_pulse` is high for one cycle, alongside the auto-refresh strobes, when the auto-refresh pulse lasted fewer than AUTO_MIN_CYC cycles. The refresh is still issued.
- R7: A high gap counts the cycles from the end of the previous pulse, including the ending cycle, up to the next pulse start. If that gap is below GAP_MIN_CYC, `viol_short_gap` is high for one cycle in the cycle after the new pulse's first low cycle. The very first pulse after reset is never flagged.
- R8: `viol_ce_early` is high in the cycle after any cycle in which `ce_n` is low and one of the following holds: that cycle is among the CE_HOLD_CYC cycles following an auto-refresh pulse start or a self-refresh exit, or a refresh pulse or self-refresh is still in progress.
- R9: For INIT_CYC cycles after reset, `init_busy` is high, both pins are ignored (no `out_en`, no refresh), and `viol_init` is high in the cycle after any cycle with either pin low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip select, active low |
| rfsh_oe_n | input | 1 | Shared output-enable / refresh pin, active low |
| out_en | output | 1 | Read output enable for the data drivers |
| refresh_stb | output | 1 | One-cycle row refresh strobe |
| refresh_row | output | ROW_W | Row refreshed with the strobe |
| auto_stb | output | 1 | One-cycle mark that an auto-refresh was issued |
| self_active | output | 1 | Self-refresh in progress |
| init_busy | output | 1 | Power-up settling interval in progress |
| viol_init | output | 1 | Pin activity during settling |
| viol_short_pulse | output | 1 | Auto-refresh pulse too short |
| viol_short_gap | output | 1 | High gap between pulses too short |
| viol_ce_early | output | 1 | Chip select asserted too soon after refresh |

## Verification
On every cycle, the assertions check the following invariants. Self-refresh is only ever entered or held while the pin was low with chip-select high. The measured width never reaches the self-refresh threshold while the mode is still undecided. A short-gap report only ever accompanies a fresh pulse. The row counter only ever moves by one. Nothing is refreshed during settling, and an auto-refresh never coincides with self-refresh. Only the bench scenarios can show that the mode boundary falls exactly at SELF_CYC, that the strobe count and row sequence are right over a long self-refresh that wraps the counter, and that each violation window opens and closes on the intended cycle.

// File: rtl/psr_pkg.sv
package psr_pkg;
  typedef enum logic [1:0] {
    PS_IDLE    = 2'd0,
    PS_MEASURE = 2'd1,
    PS_SELF    = 2'd2
  } psr_state_e;
endpackage

// File: rtl/psr_init_timer.sv
module psr_init_timer #(
  parameter int INIT_CYC = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic rfsh_oe_n,
  output logic busy,
  output logic viol_init
);
  localparam int CW = $clog2(INIT_CYC + 1);
  localparam logic [CW-1:0] INIT_LIM = CW'(INIT_CYC);

  logic [CW-1:0] cnt_q;

  assign busy = (cnt_q != INIT_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      viol_init <= 1'b0;
    end else begin
      if (busy) cnt_q <= cnt_q + 1'b1;
      viol_init <= busy && (!ce_n || !rfsh_oe_n);
    end
  end

  AST_BUSY_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !busy); // R9
endmodule

// File: rtl/psr_mode_fsm.sv
module psr_mode_fsm
  import psr_pkg::*;
#(
  parameter int SELF_CYC     = 1600,
  parameter int AUTO_MIN_CYC = 15,
  parameter int GAP_MIN_CYC  = 6,
  parameter int SELF_ROW_CYC = 3000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       ce_n,
  input  logic       rfsh_oe_n,
  output psr_state_e state,
  output logic       refresh_req,
  output logic       auto_req,
  output logic       pulse_start,
  output logic       self_exit,
  output logic       viol_short_pulse,
  output logic       viol_short_gap
);
  localparam int WW = $clog2(SELF_CYC + 1);
  localparam int TW = $clog2(SELF_ROW_CYC + 1);
  localparam int GW = $clog2(GAP_MIN_CYC + 1);
  localparam logic [WW-1:0] SELF_LIM = WW'(SELF_CYC - 1);
  localparam logic [WW-1:0] AUTO_LIM = WW'(AUTO_MIN_CYC);
  localparam logic [TW-1:0] ROW_LIM  = TW'(SELF_ROW_CYC - 1);
  localparam logic [GW-1:0] GAP_LIM  = GW'(GAP_MIN_CYC);

  psr_state_e    state_q, state_d;
  logic [WW-1:0] width_q;
  logic [TW-1:0] tmr_q;
  logic [GW-1:0] gap_q;
  logic          armed_q;
  logic          pin_low, released, self_enter, row_req;

  assign pin_low  = !rfsh_oe_n;
  assign released = rfsh_oe_n || !ce_n;
  assign state    = state_q;

  always_comb begin
    state_d     = state_q;
    pulse_start = 1'b0;
    auto_req    = 1'b0;
    self_enter  = 1'b0;
    self_exit   = 1'b0;
    row_req     = 1'b0;
    unique case (state_q)
      PS_IDLE: begin
        if (en && ce_n && pin_low) begin
          pulse_start = 1'b1;
          state_d     = PS_MEASURE;
        end
      end
      PS_MEASURE: begin
        if (released) begin
          auto_req = 1'b1;
          state_d  = PS_IDLE;
        end else if (width_q == SELF_LIM) begin
          self_enter = 1'b1;
          state_d    = PS_SELF;
        end
      end
      PS_SELF: begin
        if (released) begin
          self_exit = 1'b1;
          state_d   = PS_IDLE;
        end else if (tmr_q == ROW_LIM) begin
          row_req = 1'b1;
        end
      end
      default: state_d = PS_IDLE;
    endcase
  end

  assign refresh_req = auto_req || self_enter || row_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q          <= PS_IDLE;
      width_q          <= '0;
      tmr_q            <= '0;
      gap_q            <= '0;
      armed_q          <= 1'b0;
      viol_short_pulse <= 1'b0;
      viol_short_gap   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (pulse_start)                     width_q <= WW'(1);
      else if (state_q == PS_MEASURE)      width_q <= width_q + 1'b1;
      if (self_enter || row_req)           tmr_q <= '0;
      else if (state_q == PS_SELF)         tmr_q <= tmr_q + 1'b1;
      if (auto_req || self_exit) begin
        gap_q   <= GW'(1);
        armed_q <= 1'b1;
      end else if (state_q == PS_IDLE && rfsh_oe_n && gap_q != GAP_LIM) begin
        gap_q <= gap_q + 1'b1;
      end
      viol_short_pulse <= auto_req && (width_q < AUTO_LIM);
      viol_short_gap   <= pulse_start && armed_q && (gap_q < GAP_LIM);
    end
  end

  AST_SELF_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_SELF) |-> $past(pin_low && ce_n)); // R3
  AST_WIDTH_BELOW_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_MEASURE) |-> (width_q != '0 && width_q <= SELF_LIM)); // R3
  AST_GAP_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    viol_short_gap |-> (state_q == PS_MEASURE)); // R7
endmodule

// File: rtl/psr_ce_guard.sv
module psr_ce_guard #(
  parameter int CE_HOLD_CYC = 27
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic arm,
  input  logic busy_pulse,
  input  logic ce_n,
  output logic viol_ce_early
);
  localparam int HW = $clog2(CE_HOLD_CYC + 1);
  localparam logic [HW-1:0] HOLD_LIM = HW'(CE_HOLD_CYC);

  logic [HW-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q        <= '0;
      viol_ce_early <= 1'b0;
    end else begin
      if (arm)               hold_q <= HOLD_LIM;
      else if (hold_q != '0) hold_q <= hold_q - 1'b1;
      viol_ce_early <= en && !ce_n && ((hold_q != '0) || busy_pulse);
    end
  end

  AST_HOLD_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q == HOLD_LIM) |-> $past(arm)); // R8
endmodule

// File: rtl/psr_row_counter.sv
module psr_row_counter #(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             auto_req,
  output logic             refresh_stb,
  output logic             auto_stb,
  output logic [ROW_W-1:0] refresh_row
);
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q       <= '0;
      refresh_row <= '0;
      refresh_stb <= 1'b0;
      auto_stb    <= 1'b0;
    end else begin
      refresh_stb <= req;
      auto_stb    <= auto_req;
      if (req) begin
        refresh_row <= row_q;
        row_q       <= row_q + 1'b1;
      end
    end
  end

  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (row_q != $past(row_q)) |-> (row_q == $past(row_q) + 1'b1)); // R5
endmodule

// File: rtl/psr_rfsh_decoder.sv
module psr_rfsh_decoder
  import psr_pkg::*;
#(
  parameter int INIT_CYC     = 200000,
  parameter int AUTO_MIN_CYC = 15,
  parameter int GAP_MIN_CYC  = 6,
  parameter int SELF_CYC     = 1600,
  parameter int CE_HOLD_CYC  = 27,
  parameter int SELF_ROW_CYC = 3000,
  parameter int ROW_W        = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             rfsh_oe_n,
  output logic             out_en,
  output logic             refresh_stb,
  output logic [ROW_W-1:0] refresh_row,
  output logic             auto_stb,
  output logic             self_active,
  output logic             init_busy,
  output logic             viol_init,
  output logic             viol_short_pulse,
  output logic             viol_short_gap,
  output logic             viol_ce_early
);
  psr_state_e state;
  logic refresh_req, auto_req, pulse_start, self_exit;

  psr_init_timer #(.INIT_CYC(INIT_CYC)) u_init (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .rfsh_oe_n(rfsh_oe_n),
    .busy(init_busy), .viol_init(viol_init)
  );

  psr_mode_fsm #(
    .SELF_CYC(SELF_CYC), .AUTO_MIN_CYC(AUTO_MIN_CYC),
    .GAP_MIN_CYC(GAP_MIN_CYC), .SELF_ROW_CYC(SELF_ROW_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .en(!init_busy), .ce_n(ce_n), .rfsh_oe_n(rfsh_oe_n),
    .state(state), .refresh_req(refresh_req), .auto_req(auto_req),
    .pulse_start(pulse_start), .self_exit(self_exit),
    .viol_short_pulse(viol_short_pulse), .viol_short_gap(viol_short_gap)
  );

  psr_ce_guard #(.CE_HOLD_CYC(CE_HOLD_CYC)) u_guard (
    .clk(clk), .rst_n(rst_n), .en(!init_busy), .arm(pulse_start || self_exit),
    .busy_pulse(state != PS_IDLE), .ce_n(ce_n), .viol_ce_early(viol_ce_early)
  );

  psr_row_counter #(.ROW_W(ROW_W)) u_rows (
    .clk(clk), .rst_n(rst_n), .req(refresh_req), .auto_req(auto_req),
    .refresh_stb(refresh_stb), .auto_stb(auto_stb), .refresh_row(refresh_row)
  );

  assign self_active = (state == PS_SELF);
  assign out_en      = !init_busy && !ce_n && !rfsh_oe_n && (state == PS_IDLE);

  AST_QUIET_DURING_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    init_busy |-> (!refresh_stb && !self_active)); // R9
  AST_AUTO_NOT_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    auto_stb |-> (refresh_stb && !self_active)); // R2
endmodule

// File: tb/psr_rfsh_decoder_test.sv
module psr_rfsh_decoder_test;
  localparam int INIT = 20, AMIN = 4, GMIN = 3, SELF = 16, HOLD = 6, ROWP = 5;

  logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, rfsh_oe_n = 1'b1;
  logic out_en, refresh_stb, auto_stb, self_active, init_busy;
  logic viol_init, viol_short_pulse, viol_short_gap, viol_ce_early;
  logic [7:0] refresh_row;

  int n_chk = 0, n_fail = 0, nstb = 0;
  logic [7:0] exp_row = 8'd0;
  bit armed = 1'b0, done = 1'b0;

  always #2.5 clk = ~clk;

  psr_rfsh_decoder #(
    .INIT_CYC(INIT), .AUTO_MIN_CYC(AMIN), .GAP_MIN_CYC(GMIN), .SELF_CYC(SELF),
    .CE_HOLD_CYC(HOLD), .SELF_ROW_CYC(ROWP), .ROW_W(8)
  ) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .rfsh_oe_n(rfsh_oe_n), .out_en(out_en),
    .refresh_stb(refresh_stb), .refresh_row(refresh_row), .auto_stb(auto_stb),
    .self_active(self_active), .init_busy(init_busy), .viol_init(viol_init),
    .viol_short_pulse(viol_short_pulse), .viol_short_gap(viol_short_gap),
    .viol_ce_early(viol_ce_early)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // every tick: any strobe must carry the next expected row (R5)
  task automatic tick();
    @(posedge clk); #1;
    if (refresh_stb) begin
      chk(refresh_row == exp_row, "R5", "row", refresh_row, exp_row);
      exp_row = exp_row + 8'd1;
      nstb++;
    end
  endtask

  task automatic auto_pulse(int w, int hi);
    int n0;
    bit eg;
    eg = armed && (1 + hi < GMIN);
    rfsh_oe_n = 1'b1; ce_n = 1'b1;
    repeat (hi) tick();
    rfsh_oe_n = 1'b0; n0 = nstb;
    tick();
    chk(viol_short_gap == eg, "R7", "short gap flag", viol_short_gap, eg);
    for (int i = 1; i < w; i++) tick();
    chk(nstb == n0, "R2", "no strobe while low", nstb - n0, 0);
    rfsh_oe_n = 1'b1;
    tick();
    chk(auto_stb == 1'b1, "R2", "auto strobe", auto_stb, 1);
    chk(nstb == n0 + 1, "R2", "one refresh", nstb - n0, 1);
    chk(viol_short_pulse == (w < AMIN), "R6", "short pulse flag", viol_short_pulse, w < AMIN);
    armed = 1'b1;
  endtask

  task automatic self_pulse(int len, bit ce_exit);
    int n0, en;
    rfsh_oe_n = 1'b1; ce_n = 1'b1;
    repeat (3) tick();
    rfsh_oe_n = 1'b0; n0 = nstb;
    for (int i = 1; i <= len; i++) begin
      tick();
      if (i == SELF - 1) chk(self_active == 1'b0, "R3", "not yet self", self_active, 0);
      if (i == SELF) begin
        chk(self_active == 1'b1, "R3", "self entered", self_active, 1);
        chk(nstb == n0 + 1 && auto_stb == 1'b0, "R3", "entry refresh", nstb - n0, 1);
      end
    end
    en = 1 + (len - SELF) / ROWP;
    chk(nstb - n0 == en, "R4", "self strobes", nstb - n0, en);
    if (ce_exit) ce_n = 1'b0; else rfsh_oe_n = 1'b1;
    tick();
    chk(self_active == 1'b0, "R4", "self exit", self_active, 0);
    chk(viol_ce_early == ce_exit, "R8", "ce during self", viol_ce_early, ce_exit);
    if (ce_exit) chk(out_en == 1'b1, "R1", "out_en after exit", out_en, 1);
    ce_n = 1'b1; rfsh_oe_n = 1'b1;
    armed = 1'b1;
  endtask

  task automatic auto_hold(int j);
    bit ev;
    ev = (j <= HOLD);
    rfsh_oe_n = 1'b1; ce_n = 1'b1;
    repeat (3) tick();
    rfsh_oe_n = 1'b0;
    repeat (6) tick();
    for (int i = 6; i <= j; i++) begin
      rfsh_oe_n = 1'b1;
      ce_n = (i == j) ? 1'b0 : 1'b1;
      tick();
      if (i == j) chk(viol_ce_early == ev, "R8", "ce after auto start", viol_ce_early, ev);
    end
    ce_n = 1'b1;
    tick();
  endtask

  task automatic self_hold(int j);
    bit ev;
    ev = (j <= HOLD);
    self_pulse(SELF, 1'b0);
    repeat (j - 1) tick();
    ce_n = 1'b0;
    tick();
    chk(viol_ce_early == ev, "R8", "ce after self exit", viol_ce_early, ev);
    ce_n = 1'b1;
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(init_busy == 1'b1 && refresh_stb == 1'b0 && self_active == 1'b0, "R9", "reset state", init_busy, 1);
    chk(refresh_row == 8'd0, "R5", "reset row", refresh_row, 0);
    rst_n = 1'b1;
    tick(); tick();
    ce_n = 1'b0; rfsh_oe_n = 1'b0;
    #1 chk(out_en == 1'b0, "R9", "pins ignored in init", out_en, 0);
    tick();
    chk(viol_init == 1'b1, "R9", "init violation", viol_init, 1);
    ce_n = 1'b1;
    tick();
    chk(viol_init == 1'b1 && self_active == 1'b0, "R9", "refresh pin ignored", viol_init, 1);
    rfsh_oe_n = 1'b1;
    tick();
    chk(viol_init == 1'b0, "R9", "init quiet", viol_init, 0);
    repeat (14) tick();
    chk(init_busy == 1'b1, "R9", "busy at 19", init_busy, 1);
    tick();
    chk(init_busy == 1'b0 && nstb == 0, "R9", "busy cleared at 20", init_busy, 0);

    ce_n = 1'b0; rfsh_oe_n = 1'b0;
    #1 chk(out_en == 1'b1, "R1", "read enable", out_en, 1);
    rfsh_oe_n = 1'b1;
    #1 chk(out_en == 1'b0, "R1", "pin high", out_en, 0);
    ce_n = 1'b1; rfsh_oe_n = 1'b0;
    #1 chk(out_en == 1'b0, "R1", "ce high", out_en, 0);
    rfsh_oe_n = 1'b1;
    tick();

    for (int w = 1; w < SELF; w++) auto_pulse(w, 3);
    for (int h = 0; h <= 4; h++) auto_pulse(6, h);

    self_pulse(SELF, 1'b0);
    self_pulse(SELF + 1, 1'b0);
    self_pulse(SELF + ROWP, 1'b0);
    self_pulse(SELF + 2 * ROWP + 3, 1'b1);
    self_pulse(SELF + 260 * ROWP, 1'b0);

    for (int j = 6; j <= 9; j++) auto_hold(j);
    self_hold(HOLD);
    self_hold(HOLD + 1);

    summary();
  end
endmodule